// File: doc/BRIEF.md
# Tick-Paced On-Delay Timer

This block measures how long a condition has been switched on, in units of a periodic tick strobe. It is not enabled by a level input. It is switched on by a one-cycle arm strobe and switched off by a one-cycle disarm strobe. While it runs, it counts ticks. It raises its done flag once the elapsed count has gone strictly past a preset value. The done flag stays high until the timer is disarmed.

A control sequencer drives the arm and disarm strobes. A shared prescaler supplies the tick, one cycle wide at the wanted time base. The preset is sampled live, so it can be changed while the timer runs. Both outputs come straight from registers, so they can be read at any time.

Top module: `ondelay_timer`

## Requirements
- R1: After synchronous reset the timer is idle, with done_o = 0 and elapsed_o = 0.
- R2: An arm strobe while idle starts the timer: on the next cycle elapsed_o = 0 and done_o = 0, and ticks are counted from then on.
- R3: While running and not yet expired, each cycle with tick_i = 1 raises elapsed_o by exactly one on the next cycle.
- R4: While running, once elapsed_o > preset_i (unsigned), done_o becomes 1 on the next cycle. done_o is never 1 before that has happened since the last arm.
- R5: A disarm strobe in any state clears the timer on the next cycle: it returns to idle with done_o = 0 and elapsed_o = 0.
- R6: Once expired, done_o stays 1 and elapsed_o holds its value regardless of tick_i, until a disarm.
- R7: When arm and disarm are both 1 in the same cycle, disarm takes effect and arm has no effect.
- R8: An arm strobe while running or expired is ignored: elapsed_o is not cleared and done_o is unchanged.
- R9: elapsed_o is CNT_W bits wide (16 by default) and saturates at all ones. With preset_i at all ones the timer stays running with done_o = 0.
- R10: While running, a cycle with tick_i = 0 leaves elapsed_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base strobe, one cycle per time unit |
| arm_i | input | 1 | One-cycle strobe that switches the timer on |
| disarm_i | input | 1 | One-cycle strobe that switches the timer off; takes priority over arm |
| preset_i | input | CNT_W | Threshold that the elapsed count must exceed |
| done_o | output | 1 | Registered expiry flag |
| elapsed_o | output | CNT_W | Registered elapsed tick count |

## Verification
Every result is due one rising edge after the input that causes it. Arm, disarm and tick strobes show on elapsed_o and done_o one cycle later. Expiry shows one edge after the cycle in which elapsed_o first exceeds preset_i, which makes it two edges after the tick that pushed the count over. The bench drives inputs just after a falling edge and updates its requirement-level model at the rising edge. It then compares both outputs at the next falling edge, so every check lands exactly one register stage after its stimulus. The saturation case runs a full 2^16-tick sweep with an all-ones preset.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RUN     = 2'd1,
    ST_EXPIRED = 2'd2
  } odt_state_e;
endpackage

// File: rtl/odt_cmp.sv
module odt_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] limit_i,
  output logic         over_o
);
  // strict unsigned greater-than
  assign over_o = (value_i > limit_i);
endmodule

// File: rtl/odt_counter.sv
module odt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic at_max;
  assign at_max = (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_o <= '0;
    else if (inc_i && !at_max)
      cnt_o <= cnt_o + 1'b1;
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && cnt_o != CNT_MAX) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/odt_fsm.sv
module odt_fsm
  import odt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic disarm_i,
  input  logic tick_i,
  input  logic over_i,
  output logic clr_o,
  output logic inc_o,
  output logic done_o
);
  odt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (disarm_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:    if (arm_i)  state_d = ST_RUN;
        ST_RUN:     if (over_i) state_d = ST_EXPIRED;
        ST_EXPIRED: state_d = ST_EXPIRED;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_d == ST_EXPIRED);
    end
  end

  assign clr_o = disarm_i || (state_q == ST_IDLE && arm_i);
  assign inc_o = (state_q == ST_RUN) && tick_i && !over_i && !disarm_i;

  assert_disarm_wins_R7: assert property (@(posedge clk) disable iff (rst)
    disarm_i |=> (state_q == ST_IDLE && !done_o));

  assert_arm_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && arm_i && !disarm_i) |=> (state_q == ST_RUN && !done_o));

  assert_expire_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && over_i && !disarm_i) |=> done_o);

  assert_latched_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXPIRED && !disarm_i) |=> (state_q == ST_EXPIRED && done_o));

  assert_arm_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && arm_i && !disarm_i) |-> !clr_o);
endmodule

// File: rtl/ondelay_timer.sv
module ondelay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             done_o,
  output logic [CNT_W-1:0] elapsed_o
);
  logic over, clr, inc;

  odt_cmp #(.W(CNT_W)) u_cmp (
    .value_i (elapsed_o),
    .limit_i (preset_i),
    .over_o  (over)
  );

  odt_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_i),
    .disarm_i (disarm_i),
    .tick_i   (tick_i),
    .over_i   (over),
    .clr_o    (clr),
    .inc_o    (inc),
    .done_o   (done_o)
  );

  odt_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr),
    .inc_i (inc),
    .cnt_o (elapsed_o)
  );

  assert_no_early_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(elapsed_o > preset_i));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!done_o && elapsed_o == '0));
endmodule

// File: tb/tb_ondelay_timer.sv
module tb_ondelay_timer;
  localparam int W = 16;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic clk = 1'b0;
  logic rst, tick_i, arm_i, disarm_i;
  logic [W-1:0] preset_i;
  logic done_o;
  logic [W-1:0] elapsed_o;

  always #2 clk = ~clk;  // 250 MHz

  ondelay_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .arm_i(arm_i),
    .disarm_i(disarm_i), .preset_i(preset_i),
    .done_o(done_o), .elapsed_o(elapsed_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  // requirement-level model: 0 idle, 1 running, 2 expired
  int           m_st;
  logic [W-1:0] m_cnt;
  logic         m_done;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == ALL1) ? v : v + 1'b1;
  endfunction

  task automatic model_step();
    if (rst || disarm_i) begin
      m_st = 0; m_cnt = '0; m_done = 1'b0;
    end else if (m_st == 0) begin
      if (arm_i) begin m_st = 1; m_cnt = '0; end
    end else if (m_st == 1) begin
      if (m_cnt > preset_i) begin m_st = 2; m_done = 1'b1; end
      else if (tick_i) m_cnt = sat_inc(m_cnt);
    end
  endtask

  task automatic compare(input string tag);
    n_tests++;
    if (done_o !== m_done || elapsed_o !== m_cnt) begin
      n_fail++;
      $display("FAIL %s: done=%0b exp=%0b elapsed=%0h exp=%0h",
               tag, done_o, m_done, elapsed_o, m_cnt);
    end
  endtask

  task automatic cyc(input logic a, input logic d, input logic t, input string tag);
    arm_i = a; disarm_i = d; tick_i = t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d exp<=190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; arm_i = 0; disarm_i = 0; tick_i = 0; preset_i = 16'd3;
    m_st = 0; m_cnt = '0; m_done = 1'b0;
    @(negedge clk);
    cyc(0, 0, 0, "R1 reset");
    rst = 1'b0;
    cyc(0, 0, 1, "R1 idle ignores tick");

    // R2 start, R3 counting, R10 hold, R4 expiry with preset 3
    cyc(1, 0, 0, "R2 arm from idle");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, "R3 tick count");
    cyc(0, 0, 0, "R10 no tick holds");
    cyc(0, 0, 1, "R3 tick to 4");
    cyc(0, 0, 1, "R4 expire after exceed");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, "R6 held while expired");
    cyc(1, 0, 1, "R8 arm while expired");
    cyc(0, 1, 0, "R5 disarm from expired");

    // R8 arm while running; R7 simultaneous strobes
    cyc(1, 0, 0, "R2 arm again");
    cyc(0, 0, 1, "R3 tick");
    cyc(0, 0, 1, "R3 tick");
    cyc(1, 0, 1, "R8 arm while running");
    cyc(1, 1, 1, "R7 disarm beats arm");
    cyc(1, 1, 0, "R7 both from idle");
    cyc(0, 0, 1, "R7 stays idle");

    // preset 0: expire once count reaches 1
    preset_i = 16'd0;
    cyc(1, 0, 0, "R2 arm preset zero");
    cyc(0, 0, 1, "R3 tick to 1");
    cyc(0, 0, 0, "R4 expire preset zero");
    cyc(0, 1, 0, "R5 disarm");

    // R9 saturation with all-ones preset
    preset_i = ALL1;
    cyc(1, 0, 0, "R2 arm for saturation");
    for (int i = 0; i < 65540; i++) begin
      arm_i = 0; disarm_i = 0; tick_i = 1;
      @(posedge clk); model_step(); @(negedge clk);
    end
    compare("R9 saturate no done");
    cyc(0, 0, 1, "R9 saturated hold");
    cyc(0, 1, 0, "R5 disarm after saturation");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 63) == 0) preset_i = W'($urandom_range(0, 12));
      cyc(($urandom_range(0, 7) == 0), ($urandom_range(0, 47) == 0),
          ($urandom_range(0, 1) == 1), "random R3 R4 R6 R8");
    end

    rst = 1'b1;
    cyc(0, 0, 0, "R1 reset at end");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule